// File: doc/BRIEF.md
# Free-Running Timer with Output Compare and Input Capture

This block is a 16-bit up-counter peripheral with two compare registers, one capture register and an overflow detector. Software reaches it over an 8-bit register bus. The counter advances on a tick chosen by a two-bit clock-select field. The tick is either a prescaled copy of the system clock, at one of three divide ratios, or a rising edge on a synchronised external clock pin.

When the counter equals a compare register, the next tick does three things:
- it sets that compare's status flag;
- it drives the matching compare output pin to a level held in a control register;
- for compare A only, it can optionally reload the counter with zero, which makes a periodic timer.

A chosen edge on the synchronised capture pin copies the counter into the capture register and sets a capture flag. Each of the four flags has its own enable. An interrupt request output is high while both its flag and its enable are set.

The 16-bit registers are reached one byte at a time. A write to a high byte is parked in a temporary byte and commits together with the low-byte write. A read of a high byte snapshots the low byte, so that the two halves of a read are coherent. Both compare registers share one address pair, steered by a select bit.

Top module: `cmpcap_timer`

## Requirements
- R1: After reset the counter, the capture register, the clock select, the edge select, the compare select, both pin levels, all flags, all enables and clear-on-A read 0, and both compare registers read 0xFFFF.
- R2: Register byte offsets are 0x10 enables, 0x11 status, 0x12/0x13 counter high/low, 0x14/0x15 compare high/low, 0x16 timer control, 0x17 compare control, 0x18/0x19 capture high/low. Unimplemented bits read 0: timer control keeps bits 7,1,0 (mask 0x83), compare control keeps bits 4,1,0 (mask 0x13) and enables keep bits 7,3,2,1 (mask 0x8E).
- R3: Writing a high byte (0x12 or 0x14) changes no register until the matching low byte is written, and then the full 16-bit value is loaded. Reading 0x12 or 0x18 latches the low byte, and a later read of 0x13 or 0x19 returns that latched byte.
- R4: Timer control bits 1:0 select the tick: 00 every 8 clocks, 01 every 32 clocks, 10 every 128 clocks, 11 each rising edge of the synchronised external clock. The counter changes only on a tick or a software write.
- R5: When the counter equals a compare register, the following tick sets that compare's flag (status bit 3 for A, bit 2 for B). On the same tick the output pin takes the level in compare control bit 1 (A) or bit 0 (B).
- R6: Compare control bit 4 steers the 0x14/0x15 pair: 0 reaches compare A, 1 reaches compare B.
- R7: With status bit 0 set, a compare-A match reloads the counter with 0 on its tick, so compare value N gives a period of N+1 ticks and the counter never exceeds N.
- R8: A tick taken at count 0xFFFF (with no compare-A clear) wraps the counter to 0x0000 and sets status bit 1.
- R9: Timer control bit 7 selects the capture edge (1 rising, 0 falling). On that edge of the synchronised capture pin the counter is copied into the capture register and status bit 7 is set, and the other edge has no effect.
- R10: Writing 0 to a status flag bit clears it and writing 1 leaves it unchanged. A hardware set in the same cycle as a clearing write leaves the flag set.
- R11: Each interrupt output equals its status flag ANDed with the enable at the same bit position (7 capture, 3 compare A, 2 compare B, 1 overflow).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe, one cycle per byte |
| busRd | input | 1 | Read strobe, one cycle per byte |
| busAddr | input | 5 | Byte offset within the block |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from busAddr |
| extClk | input | 1 | External count clock, asynchronous |
| capIn | input | 1 | Capture trigger pin, asynchronous |
| cmpOutA | output | 1 | Compare A output level |
| cmpOutB | output | 1 | Compare B output level |
| irqCapture | output | 1 | Capture interrupt request |
| irqCmpA | output | 1 | Compare A interrupt request |
| irqCmpB | output | 1 | Compare B interrupt request |
| irqOvf | output | 1 | Overflow interrupt request |

## Verification
The delicate overlap is a hardware flag set and a software write of 0 to the status register landing in the same cycle. The bench provokes it with the capture path. It raises the capture pin at a known falling clock edge. The set then arrives a fixed number of edges later, once the pin has passed the synchroniser and the edge detector, and the bench places the status write on exactly that edge. It judges the result from the status read-back and the capture interrupt pin, which must both still show the flag. The period of the compare-A clear is timed to the cycle from the interrupt pin, because a match there coincides with the counter reload.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_IRQEN = 5'h10;
  localparam logic [ADDR_W-1:0] A_STAT  = 5'h11;
  localparam logic [ADDR_W-1:0] A_CNTH  = 5'h12;
  localparam logic [ADDR_W-1:0] A_CNTL  = 5'h13;
  localparam logic [ADDR_W-1:0] A_CMPH  = 5'h14;
  localparam logic [ADDR_W-1:0] A_CMPL  = 5'h15;
  localparam logic [ADDR_W-1:0] A_TCTL  = 5'h16;
  localparam logic [ADDR_W-1:0] A_OCTL  = 5'h17;
  localparam logic [ADDR_W-1:0] A_CAPH  = 5'h18;
  localparam logic [ADDR_W-1:0] A_CAPL  = 5'h19;

  // flag / enable bit positions
  localparam int B_CAP  = 7;
  localparam int B_CMPA = 3;
  localparam int B_CMPB = 2;
  localparam int B_OVF  = 1;
  localparam int B_CLRA = 0;
  // control bit positions
  localparam int B_EDGE   = 7;
  localparam int B_CMPSEL = 4;
  localparam int B_LVLA   = 1;
  localparam int B_LVLB   = 0;

  // control -> datapath strobes and settings
  typedef struct packed {
    logic              wrCnt;
    logic              wrCmpA;
    logic              wrCmpB;
    logic [WORD_W-1:0] wrWord;
    logic [1:0]        clkSel;
    logic              capRise;
    logic              clrOnA;
    logic              lvlA;
    logic              lvlB;
  } ctrlStrobe_t;

  // datapath -> control flag-set events
  typedef struct packed {
    logic setCap;
    logic setCmpA;
    logic setCmpB;
    logic setOvf;
  } evt_t;
endpackage

// File: rtl/cct_sync.sv
module cct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  generate
    if (STAGES <= 1) begin : g_single
      logic stage;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= 1'b0;
        else       stage <= din;
      end
      assign dout = stage;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din};
      end
      assign dout = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cct_dpath.sv
module cct_dpath
  import cct_pkg::*;
#(
  parameter int DIV0_LOG2   = 3,
  parameter int DIV1_LOG2   = 5,
  parameter int DIV2_LOG2   = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic              extClk,
  input  logic              capIn,
  output logic [WORD_W-1:0] count,
  output logic [WORD_W-1:0] cmpA,
  output logic [WORD_W-1:0] cmpB,
  output logic [WORD_W-1:0] capVal,
  output evt_t              evt,
  output logic              pinA,
  output logic              pinB
);
  localparam int MAX01 = (DIV0_LOG2 > DIV1_LOG2) ? DIV0_LOG2 : DIV1_LOG2;
  localparam int PRE_W = (MAX01 > DIV2_LOG2) ? MAX01 : DIV2_LOG2;
  localparam int NDIV  = 3;
  localparam int DIV_LOG2 [NDIV] = '{DIV0_LOG2, DIV1_LOG2, DIV2_LOG2};

  // free-running prescaler shared by all internal ratios
  logic [PRE_W-1:0] preCnt;
  logic [NDIV-1:0]  intTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  generate
    for (genvar i = 0; i < NDIV; i++) begin : g_div
      localparam logic [PRE_W-1:0] MASK = PRE_W'((1 << DIV_LOG2[i]) - 1);
      assign intTick[i] = &(preCnt | ~MASK);
    end
  endgenerate

  // external clock and capture pin synchronisers with edge detect
  logic extS, extPrev, capS, capPrev;
  logic extTick, capEdge;

  cct_sync #(.STAGES(SYNC_STAGES)) u_extSync (.clk(clk), .rstN(rstN), .din(extClk), .dout(extS));
  cct_sync #(.STAGES(SYNC_STAGES)) u_capSync (.clk(clk), .rstN(rstN), .din(capIn),  .dout(capS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extPrev <= 1'b0;
      capPrev <= 1'b0;
    end else begin
      extPrev <= extS;
      capPrev <= capS;
    end
  end

  assign extTick = extS & ~extPrev;
  assign capEdge = strb.capRise ? (capS & ~capPrev) : (~capS & capPrev);

  logic tick;
  always_comb begin
    case (strb.clkSel)
      2'd0:    tick = intTick[0];
      2'd1:    tick = intTick[1];
      2'd2:    tick = intTick[2];
      default: tick = extTick;
    endcase
  end

  logic hitA, hitB, clearNow, wrapNow;
  assign hitA     = (count == cmpA);
  assign hitB     = (count == cmpB);
  assign clearNow = tick && hitA && strb.clrOnA;
  assign wrapNow  = tick && !clearNow && (&count);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            count <= '0;
    else if (strb.wrCnt)  count <= strb.wrWord;
    else if (clearNow)    count <= '0;
    else if (tick)        count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpA <= '1;
      cmpB <= '1;
    end else begin
      if (strb.wrCmpA) cmpA <= strb.wrWord;
      if (strb.wrCmpB) cmpB <= strb.wrWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        capVal <= '0;
    else if (capEdge) capVal <= count;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinA <= 1'b0;
      pinB <= 1'b0;
    end else begin
      if (tick && hitA) pinA <= strb.lvlA;
      if (tick && hitB) pinB <= strb.lvlB;
    end
  end

  assign evt.setCap  = capEdge;
  assign evt.setCmpA = tick && hitA;
  assign evt.setCmpB = tick && hitB;
  assign evt.setOvf  = wrapNow;

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !strb.wrCnt) |=> $stable(count)); // R4
  AST_CLEAR_ON_A: assert property (@(posedge clk) disable iff (!rstN)
    (tick && hitA && strb.clrOnA && !strb.wrCnt) |=> (count == '0)); // R7
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (tick && (&count) && !(hitA && strb.clrOnA) && !strb.wrCnt) |=> (count == '0)); // R8
  AST_CAPTURE_COPY: assert property (@(posedge clk) disable iff (!rstN)
    capEdge |=> (capVal == $past(count))); // R9
  AST_PIN_A_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (tick && hitA) |=> (pinA == $past(strb.lvlA))); // R5
endmodule

// File: rtl/cct_ctrl.sv
module cct_ctrl
  import cct_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  evt_t              evt,
  input  logic [WORD_W-1:0] count,
  input  logic [WORD_W-1:0] cmpA,
  input  logic [WORD_W-1:0] cmpB,
  input  logic [WORD_W-1:0] capVal,
  output ctrlStrobe_t       strb,
  output logic              irqCapture,
  output logic              irqCmpA,
  output logic              irqCmpB,
  output logic              irqOvf
);
  logic enCap, enA, enB, enOvf;
  logic flagCap, flagA, flagB, flagOvf, clrOnA;
  logic edgeRise, cmpSel, lvlA, lvlB;
  logic [1:0] clkSel;
  logic [BYTE_W-1:0] tmpWr, tmpRd;

  logic stWr;
  assign stWr = busWr && (busAddr == A_STAT);

  // control and enable registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enCap <= 1'b0; enA <= 1'b0; enB <= 1'b0; enOvf <= 1'b0;
      clrOnA <= 1'b0; edgeRise <= 1'b0; clkSel <= 2'b00;
      cmpSel <= 1'b0; lvlA <= 1'b0; lvlB <= 1'b0;
    end else if (busWr) begin
      case (busAddr)
        A_IRQEN: begin
          enCap <= busWdata[B_CAP];  enA   <= busWdata[B_CMPA];
          enB   <= busWdata[B_CMPB]; enOvf <= busWdata[B_OVF];
        end
        A_STAT: clrOnA <= busWdata[B_CLRA];
        A_TCTL: begin
          edgeRise <= busWdata[B_EDGE];
          clkSel   <= busWdata[1:0];
        end
        A_OCTL: begin
          cmpSel <= busWdata[B_CMPSEL];
          lvlA   <= busWdata[B_LVLA];
          lvlB   <= busWdata[B_LVLB];
        end
        default: ;
      endcase
    end
  end

  // flags: software may only clear, a hardware set always wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagCap <= 1'b0; flagA <= 1'b0; flagB <= 1'b0; flagOvf <= 1'b0;
    end else begin
      flagCap <= (flagCap & ~(stWr & ~busWdata[B_CAP]))  | evt.setCap;
      flagA   <= (flagA   & ~(stWr & ~busWdata[B_CMPA])) | evt.setCmpA;
      flagB   <= (flagB   & ~(stWr & ~busWdata[B_CMPB])) | evt.setCmpB;
      flagOvf <= (flagOvf & ~(stWr & ~busWdata[B_OVF]))  | evt.setOvf;
    end
  end

  // byte-wide temporaries for 16-bit access
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmpWr <= '0;
      tmpRd <= '0;
    end else begin
      if (busWr && (busAddr == A_CNTH || busAddr == A_CMPH)) tmpWr <= busWdata;
      if (busRd && busAddr == A_CNTH) tmpRd <= count[BYTE_W-1:0];
      else if (busRd && busAddr == A_CAPH) tmpRd <= capVal[BYTE_W-1:0];
    end
  end

  always_comb begin
    strb.wrCnt   = busWr && (busAddr == A_CNTL);
    strb.wrCmpA  = busWr && (busAddr == A_CMPL) && !cmpSel;
    strb.wrCmpB  = busWr && (busAddr == A_CMPL) && cmpSel;
    strb.wrWord  = {tmpWr, busWdata};
    strb.clkSel  = clkSel;
    strb.capRise = edgeRise;
    strb.clrOnA  = clrOnA;
    strb.lvlA    = lvlA;
    strb.lvlB    = lvlB;
  end

  logic [WORD_W-1:0] cmpView;
  assign cmpView = cmpSel ? cmpB : cmpA;

  always_comb begin
    case (busAddr)
      A_IRQEN: busRdata = {enCap, 3'b000, enA, enB, enOvf, 1'b0};
      A_STAT:  busRdata = {flagCap, 3'b000, flagA, flagB, flagOvf, clrOnA};
      A_CNTH:  busRdata = count[WORD_W-1:BYTE_W];
      A_CNTL:  busRdata = tmpRd;
      A_CMPH:  busRdata = cmpView[WORD_W-1:BYTE_W];
      A_CMPL:  busRdata = cmpView[BYTE_W-1:0];
      A_TCTL:  busRdata = {edgeRise, 5'b00000, clkSel};
      A_OCTL:  busRdata = {3'b000, cmpSel, 2'b00, lvlA, lvlB};
      A_CAPH:  busRdata = capVal[WORD_W-1:BYTE_W];
      A_CAPL:  busRdata = tmpRd;
      default: busRdata = '0;
    endcase
  end

  assign irqCapture = flagCap & enCap;
  assign irqCmpA    = flagA & enA;
  assign irqCmpB    = flagB & enB;
  assign irqOvf     = flagOvf & enOvf;

  AST_SET_WINS_CAP: assert property (@(posedge clk) disable iff (!rstN)
    evt.setCap |=> flagCap); // R10
  AST_SET_WINS_CMPA: assert property (@(posedge clk) disable iff (!rstN)
    evt.setCmpA |=> flagA); // R10
  AST_SW_CLEAR_OVF: assert property (@(posedge clk) disable iff (!rstN)
    (stWr && !busWdata[B_OVF] && !evt.setOvf) |=> !flagOvf); // R10
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!evt.setOvf && !stWr) |=> $stable(flagOvf)); // R10
endmodule

// File: rtl/cmpcap_timer.sv
module cmpcap_timer
  import cct_pkg::*;
#(
  parameter int DIV0_LOG2   = 3,
  parameter int DIV1_LOG2   = 5,
  parameter int DIV2_LOG2   = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic              extClk,
  input  logic              capIn,
  output logic              cmpOutA,
  output logic              cmpOutB,
  output logic              irqCapture,
  output logic              irqCmpA,
  output logic              irqCmpB,
  output logic              irqOvf
);
  ctrlStrobe_t       strb;
  evt_t              evt;
  logic [WORD_W-1:0] count, cmpA, cmpB, capVal;

  cct_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .evt(evt), .count(count), .cmpA(cmpA), .cmpB(cmpB), .capVal(capVal),
    .strb(strb),
    .irqCapture(irqCapture), .irqCmpA(irqCmpA), .irqCmpB(irqCmpB), .irqOvf(irqOvf)
  );

  cct_dpath #(
    .DIV0_LOG2(DIV0_LOG2), .DIV1_LOG2(DIV1_LOG2), .DIV2_LOG2(DIV2_LOG2),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .extClk(extClk), .capIn(capIn),
    .count(count), .cmpA(cmpA), .cmpB(cmpB), .capVal(capVal),
    .evt(evt), .pinA(cmpOutA), .pinB(cmpOutB)
  );
endmodule

// File: tb/cmpcap_timer_tb.sv
`timescale 1ns/1ps
module cmpcap_timer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [4:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic extClk = 1'b0, capIn = 1'b0;
  logic cmpOutA, cmpOutB, irqCapture, irqCmpA, irqCmpB, irqOvf;

  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  cmpcap_timer u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .extClk(extClk), .capIn(capIn),
    .cmpOutA(cmpOutA), .cmpOutB(cmpOutB), .irqCapture(irqCapture),
    .irqCmpA(irqCmpA), .irqCmpB(irqCmpB), .irqOvf(irqOvf)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    busRd = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic rdWord(input logic [4:0] hiA, output logic [15:0] w);
    logic [7:0] h, l;
    rd(hiA, h);
    rd(hiA + 5'd1, l);
    w = {h, l};
  endtask

  task automatic wrWord(input logic [4:0] hiA, input logic [15:0] w);
    wr(hiA, w[15:8]);
    wr(hiA + 5'd1, w[7:0]);
  endtask

  function automatic int ticksFor(input int sel, input int edges);
    int div;
    div = (sel == 0) ? 8 : (sel == 1) ? 32 : 128;
    return edges / div;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin : main
    logic [7:0] b;
    logic [15:0] w, mA, mB, x, y;
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdWord(5'h12, w); chk("R1 counter reset (<=1 tick)", int'(w <= 16'd1), 1);
    rdWord(5'h14, w); chk("R1 compare A reset", w, 16'hFFFF);
    wr(5'h17, 8'h10);
    rdWord(5'h14, w); chk("R1 compare B reset", w, 16'hFFFF);
    wr(5'h17, 8'h00);
    rd(5'h11, b); chk("R1 status reset", b, 8'h00);
    rd(5'h10, b); chk("R1 enable reset", b, 8'h00);
    rd(5'h16, b); chk("R1 timer control reset", b, 8'h00);
    rdWord(5'h18, w); chk("R1 capture reset", w, 16'h0000);
    chk("R1 irq pins reset", {irqCapture, irqCmpA, irqCmpB, irqOvf}, 0);
    chk("R1 compare pins reset", {cmpOutA, cmpOutB}, 0);

    // R2 readback masks
    wr(5'h16, 8'hFF); rd(5'h16, b); chk("R2 timer control mask", b, 8'h83);
    wr(5'h16, 8'h03);
    wr(5'h17, 8'hFF); rd(5'h17, b); chk("R2 compare control mask", b, 8'h13);
    for (int i = 0; i < 6; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      wr(5'h10, r); rd(5'h10, b); chk("R2 enable mask", b, int'(r & 8'h8E));
    end
    wr(5'h10, 8'h00);

    // R3 / R6 random compare traffic, counter frozen (external mode, idle pin)
    mA = 16'hFFFF; mB = 16'hFFFF;
    for (int i = 0; i < 16; i++) begin
      logic sel;
      sel = 1'($urandom);
      w = 16'($urandom);
      wr(5'h17, {3'b000, sel, 4'b0000});
      wrWord(5'h14, w);
      if (sel) mB = w; else mA = w;
      wr(5'h14, 8'($urandom));
      rdWord(5'h14, x); chk("R3 high byte write held", x, sel ? mB : mA);
      wr(5'h17, {3'b000, ~sel, 4'b0000});
      rdWord(5'h14, x); chk("R6 other compare untouched", x, sel ? mA : mB);
    end

    // R3 low-byte read returns snapshot from high-byte read
    x = 16'($urandom); y = x ^ 16'h5A5A;
    wrWord(5'h12, x);
    rd(5'h12, b); chk("R3 counter high read", b, x[15:8]);
    wrWord(5'h12, y);
    rd(5'h13, b); chk("R3 counter low snapshot", b, x[7:0]);

    // R4 internal rates: ticks in k edges after the counter write
    for (int s = 0; s < 3; s++) begin
      int k;
      k = (s == 0) ? 800 : (s == 1) ? 3200 : 12800;
      wr(5'h16, 8'(s));
      wrWord(5'h12, 16'h0000);
      repeat (k - 1) @(negedge clk);
      rdWord(5'h12, w);
      chk($sformatf("R4 rate select %0d", s), w, ticksFor(s, k));
    end

    // R4 external rising edges
    wr(5'h16, 8'h03);
    wrWord(5'h12, 16'h0000);
    for (int p = 0; p < 20; p++) begin
      @(negedge clk) extClk = 1'b1;
      repeat (3) @(negedge clk);
      extClk = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    rdWord(5'h12, w); chk("R4 external edge count", w, 20);

    // R5 / R7 / R11 compare A clear every 64 ticks of /8
    wr(5'h16, 8'h00);
    wr(5'h17, 8'h02); wrWord(5'h14, 16'd63);
    wr(5'h17, 8'h13); wrWord(5'h14, 16'd10);
    wr(5'h11, 8'h01);
    wrWord(5'h12, 16'h0000);
    wr(5'h10, 8'h0C);
    wait (irqCmpA === 1'b1);
    chk("R5 compare A pin level", cmpOutA, 1);
    chk("R5 compare B pin level", cmpOutB, 1);
    chk("R11 compare B irq", irqCmpB, 1);
    wr(5'h11, 8'h01);
    chk("R10 write 0 clears compare A", irqCmpA, 0);
    n = 1;
    while (irqCmpA !== 1'b1) begin
      @(negedge clk); n++;
    end
    chk("R7 clear-on-A period cycles", n, 64 * 8);
    for (int i = 0; i < 8; i++) begin
      repeat (int'($urandom_range(40, 1))) @(negedge clk);
      rdWord(5'h12, w); chk("R7 counter never above compare A", int'(w <= 16'd63), 1);
    end
    rd(5'h11, b); chk("R5 status A and B flags", b & 8'h0C, 8'h0C);
    wr(5'h10, 8'h08);
    chk("R11 irq B gated by enable", irqCmpB, 0);
    rd(5'h11, b); chk("R10 flag B kept when writing 1", b[2], 1);

    // R8 overflow
    wr(5'h11, 8'h00);
    wr(5'h10, 8'h02);
    wrWord(5'h12, 16'hFFF0);
    repeat (99) @(negedge clk);
    chk("R8 no overflow before wrap", irqOvf, 0);
    repeat (40) @(negedge clk);
    chk("R8 overflow irq after wrap", irqOvf, 1);
    rdWord(5'h12, w); chk("R8 counter wrapped low", int'(w <= 16'd4), 1);

    // R9 capture, counter frozen in external mode
    wr(5'h16, 8'h83);
    wr(5'h11, 8'h00);
    wr(5'h10, 8'h80);
    x = 16'($urandom); y = ~x;
    wrWord(5'h12, x);
    @(negedge clk) capIn = 1'b1;
    repeat (5) @(negedge clk);
    rdWord(5'h18, w); chk("R9 rising capture value", w, x);
    chk("R9 capture irq", irqCapture, 1);
    wr(5'h11, 8'h00);
    wrWord(5'h12, y);
    @(negedge clk) capIn = 1'b0;
    repeat (5) @(negedge clk);
    rdWord(5'h18, w); chk("R9 falling edge ignored", w, x);
    chk("R9 no flag on wrong edge", irqCapture, 0);
    wr(5'h16, 8'h03);
    @(negedge clk) capIn = 1'b1;
    repeat (5) @(negedge clk);
    rdWord(5'h18, w); chk("R9 rising ignored in falling mode", w, x);
    @(negedge clk) capIn = 1'b0;
    repeat (5) @(negedge clk);
    rdWord(5'h18, w); chk("R9 falling capture value", w, y);

    // R10 hardware set coincides with software clear
    wr(5'h16, 8'h83);
    wr(5'h11, 8'h00);
    chk("R10 capture flag cleared", irqCapture, 0);
    @(negedge clk) capIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    busWr = 1'b1; busAddr = 5'h11; busWdata = 8'h00;
    @(negedge clk);
    busWr = 1'b0;
    chk("R10 set wins over clear (irq)", irqCapture, 1);
    rd(5'h11, b); chk("R10 set wins over clear (status)", b[7], 1);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule